// File: doc/BRIEF.md
# Serial Channel Error Flag Unit

This block produces the error status bits of a serial channel that runs in one of three modes. The modes are an asynchronous UART, a clocked shift interface whose clock comes from the far end (slave), and a clocked shift interface that drives its own clock (master). It watches the events the channel's datapath reports: completed receive frames with their parity and stop samples, completed transmit shifts, and transfer clock edges. From these it raises sticky parity, framing, overrun and underrun flags.

The flags appear in an 8-bit status register image. One bit is shared: it reports a parity mismatch in UART mode and a transmit underrun in slave mode. Reading the register clears every flag. An error event that lands in the same cycle as the read wins, so no error is lost. The receiver judges the frame by its first stop sample only, whatever stop length the transmitter is set to.

Top module: `ser_err_flags`

## Requirements
- R1: After reset every bit of `sts_o` is 0. Bits 7:5 and 1:0 are always 0. Bit 2 is framing, bit 3 is parity/underrun and bit 4 is overrun.
- R2: In UART mode (`mode_i`=0), a `rx_done_i` pulse with `par_en_i`=1 sets bit 3 when `rx_par_i` differs from the expected parity. Expected parity is the XOR of `rx_data_i` when `par_odd_i`=0, and its inverse when `par_odd_i`=1. With `par_en_i`=0 the parity bit is not checked.
- R3: In UART mode a `rx_done_i` pulse with `rx_stop_i[0]`=0 sets bit 2. `rx_stop_i[1]` (the second stop sample) and `stop_len_i` never affect bit 2.
- R4: A `rx_done_i` pulse with `rx_full_i`=1 sets bit 4 in any mode, except master mode (`mode_i[1]`=1) with `dbuf_en_i`=0, where bit 4 stays 0.
- R5: In slave mode (`mode_i`=1) with `dbuf_en_i`=1, a `shift_done_i` pulse arms the check. At the next `sclk_edge_i`, bit 3 is set if no transmit data is ready.
- R6: Transmit data is ready when `tx_buf_full_i`=1, or when `tx_fifo_en_i`=1 and `tx_fifo_cnt_i` is non-zero. The FIFO count is ignored while the FIFO is disabled.
- R7: With `dbuf_en_i`=0 the underrun is never flagged. Bit 3 never rises in master mode, and bit 2 never rises outside UART mode.
- R8: `rd_stb_i` clears all flags at the clock edge. A flag whose error event occurs in the same cycle is left set.
- R9: A set flag holds without a read, across idle cycles and mode changes.
- R10: Only the first `sclk_edge_i` after `shift_done_i` is checked. Data made ready before that edge prevents the underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 UART, 1 clocked slave, 2 or 3 clocked master |
| dbuf_en_i | input | 1 | Transmit double buffer enable |
| stop_len_i | input | 1 | Configured stop length (1 = two bits); no effect on checking |
| rx_done_i | input | 1 | One-cycle pulse: a frame was received |
| rx_data_i | input | DATA_W | Received data bits |
| par_en_i | input | 1 | Parity enabled |
| par_odd_i | input | 1 | Odd parity when 1 |
| rx_par_i | input | 1 | Received parity bit |
| rx_stop_i | input | 2 | Mid-bit stop samples: [0] first, [1] second |
| rx_full_i | input | 1 | Receive buffer still holds unread data |
| shift_done_i | input | 1 | Pulse: transmit shift register finished a transfer |
| sclk_edge_i | input | 1 | Pulse: transfer clock starts the next transfer |
| tx_buf_full_i | input | 1 | Transmit double buffer holds data |
| tx_fifo_en_i | input | 1 | Transmit FIFO enabled |
| tx_fifo_cnt_i | input | CNT_W | Transmit FIFO occupancy |
| rd_stb_i | input | 1 | Status register read strobe |
| sts_o | output | 8 | Status register image |

## Verification
A wrong flag register or a missed event shows on `sts_o` one edge after the event. A wrongly held flag shows one edge after a clearing read. A wrong underrun arming state is hidden until the next transfer clock edge. The bench therefore places edges several idle cycles after the shift completes, fires second edges without a new shift, and compares every cycle against a behavioural model. Bits whose meaning is undefined in the current mode are masked out.

// File: rtl/ser_err_pkg.sv
package ser_err_pkg;
  localparam int STS_W  = 8;
  localparam int FE_BIT = 2;
  localparam int PU_BIT = 3;
  localparam int OV_BIT = 4;
  localparam int NFLAG  = 3;
  localparam int FLG_FE = 0;
  localparam int FLG_PU = 1;
  localparam int FLG_OV = 2;

  typedef enum logic [1:0] {
    MODE_UART    = 2'd0,
    MODE_SLV     = 2'd1,
    MODE_MST     = 2'd2,
    MODE_MST_ALT = 2'd3
  } ser_mode_e;
endpackage

// File: rtl/ser_rx_chk.sv
module ser_rx_chk
  import ser_err_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        mode_i,
  input  logic              dbuf_en_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rx_par_i,
  input  logic              stop0_i,
  input  logic              rx_full_i,
  output logic              pe_evt_o,
  output logic              fe_evt_o,
  output logic              ov_evt_o
);
  ser_mode_e mode;
  logic      uart, mst, exp_par;

  always_comb begin
    mode    = ser_mode_e'(mode_i);
    uart    = (mode == MODE_UART);
    mst     = (mode == MODE_MST) || (mode == MODE_MST_ALT);
    exp_par = par_odd_i ? ~(^rx_data_i) : (^rx_data_i);
  end

  assign pe_evt_o = uart && rx_done_i && par_en_i && (rx_par_i != exp_par);
  // only the first stop sample is judged
  assign fe_evt_o = uart && rx_done_i && !stop0_i;
  // master without double buffer cannot report overrun
  assign ov_evt_o = rx_done_i && rx_full_i && !(mst && !dbuf_en_i);
endmodule

// File: rtl/ser_underrun.sv
module ser_underrun
  import ser_err_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             dbuf_en_i,
  input  logic             shift_done_i,
  input  logic             sclk_edge_i,
  input  logic             tx_buf_full_i,
  input  logic             tx_fifo_en_i,
  input  logic [CNT_W-1:0] tx_fifo_cnt_i,
  output logic             ur_evt_o
);
  logic armed_q, armed_d, active, have_data;

  always_comb begin
    active    = (ser_mode_e'(mode_i) == MODE_SLV) && dbuf_en_i;
    have_data = tx_buf_full_i || (tx_fifo_en_i && (tx_fifo_cnt_i != '0));
    if (!active)           armed_d = 1'b0;
    else if (shift_done_i) armed_d = 1'b1;
    else if (sclk_edge_i)  armed_d = 1'b0;
    else                   armed_d = armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  assign ur_evt_o = active && armed_q && sclk_edge_i && !have_data;
endmodule

// File: rtl/ser_flag.sv
module ser_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // a set in the clearing cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ser_err_flags.sv
module ser_err_flags
  import ser_err_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              dbuf_en_i,
  input  logic              stop_len_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rx_par_i,
  input  logic [1:0]        rx_stop_i,
  input  logic              rx_full_i,
  input  logic              shift_done_i,
  input  logic              sclk_edge_i,
  input  logic              tx_buf_full_i,
  input  logic              tx_fifo_en_i,
  input  logic [CNT_W-1:0]  tx_fifo_cnt_i,
  input  logic              rd_stb_i,
  output logic [STS_W-1:0]  sts_o
);
  logic             pe_evt, fe_evt, ov_evt, ur_evt;
  logic [NFLAG-1:0] evt, flag;

  ser_rx_chk #(.DATA_W(DATA_W)) u_rx_chk (
    .mode_i    (mode_i),
    .dbuf_en_i (dbuf_en_i),
    .rx_done_i (rx_done_i),
    .rx_data_i (rx_data_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .rx_par_i  (rx_par_i),
    .stop0_i   (rx_stop_i[0]),
    .rx_full_i (rx_full_i),
    .pe_evt_o  (pe_evt),
    .fe_evt_o  (fe_evt),
    .ov_evt_o  (ov_evt)
  );

  ser_underrun #(.FIFO_DEPTH(FIFO_DEPTH)) u_underrun (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_i),
    .dbuf_en_i     (dbuf_en_i),
    .shift_done_i  (shift_done_i),
    .sclk_edge_i   (sclk_edge_i),
    .tx_buf_full_i (tx_buf_full_i),
    .tx_fifo_en_i  (tx_fifo_en_i),
    .tx_fifo_cnt_i (tx_fifo_cnt_i),
    .ur_evt_o      (ur_evt)
  );

  always_comb begin
    evt         = '0;
    evt[FLG_FE] = fe_evt;
    evt[FLG_PU] = pe_evt | ur_evt;
    evt[FLG_OV] = ov_evt;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ser_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt[g]),
      .clr_i  (rd_stb_i),
      .q_o    (flag[g])
    );
  end

  always_comb begin
    sts_o         = '0;
    sts_o[FE_BIT] = flag[FLG_FE];
    sts_o[PU_BIT] = flag[FLG_PU];
    sts_o[OV_BIT] = flag[FLG_OV];
  end
endmodule

// File: rtl/ser_err_flags_chk.sv
module ser_err_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       dbuf_en_i,
  input logic       stop_len_i,
  input logic       rx_done_i,
  input logic [1:0] rx_stop_i,
  input logic       rd_stb_i,
  input logic [2:0] evt,
  input logic [7:0] sts_o
);
  // R7
  fe_uart_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[2]) |-> ($past(mode_i) == 2'd0));
  // R7
  pu_not_mst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[3]) |-> !$past(mode_i[1]));
  // R7
  ur_needs_dbuf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sts_o[3]) && ($past(mode_i) == 2'd1)) |-> $past(dbuf_en_i));
  // R4
  ov_mst_nodbuf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[4]) |-> !($past(mode_i[1]) && !$past(dbuf_en_i)));
  // R3
  second_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rx_stop_i[0] && !rx_stop_i[1] && stop_len_i && !sts_o[2])
      |=> !sts_o[2]);
  // R8
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && (evt == 3'b000)) |=> (sts_o[4:2] == 3'b000));
  // R8
  fe_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt[0] |=> sts_o[2]);
  // R8
  pu_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt[1] |=> sts_o[3]);
  // R8
  ov_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt[2] |=> sts_o[4]);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_stb_i && (evt == 3'b000)) |=> $stable(sts_o));
endmodule

bind ser_err_flags ser_err_flags_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .dbuf_en_i  (dbuf_en_i),
  .stop_len_i (stop_len_i),
  .rx_done_i  (rx_done_i),
  .rx_stop_i  (rx_stop_i),
  .rd_stb_i   (rd_stb_i),
  .evt        (evt),
  .sts_o      (sts_o)
);

// File: tb/ser_err_flags_test.sv
`timescale 1ns/1ps
module ser_err_flags_test;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic              dbuf = 1'b0, stop_len = 1'b0, rx_done = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic              par_en = 1'b0, par_odd = 1'b0, rx_par = 1'b0;
  logic [1:0]        rx_stop = 2'b11;
  logic              rx_full = 1'b0, shift_done = 1'b0, sclk_edge = 1'b0;
  logic              tx_full = 1'b0, fifo_en = 1'b0;
  logic [CNT_W-1:0]  fifo_cnt = '0;
  logic              rd = 1'b0;
  logic [7:0]        sts;

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  ser_err_flags #(.DATA_W(DATA_W), .FIFO_DEPTH(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dbuf_en_i(dbuf),
    .stop_len_i(stop_len), .rx_done_i(rx_done), .rx_data_i(rx_data),
    .par_en_i(par_en), .par_odd_i(par_odd), .rx_par_i(rx_par),
    .rx_stop_i(rx_stop), .rx_full_i(rx_full), .shift_done_i(shift_done),
    .sclk_edge_i(sclk_edge), .tx_buf_full_i(tx_full), .tx_fifo_en_i(fifo_en),
    .tx_fifo_cnt_i(fifo_cnt), .rd_stb_i(rd), .sts_o(sts)
  );

  // behavioural reference
  bit m_fe, m_pu, m_ov, m_wait;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fe <= 0; m_pu <= 0; m_ov <= 0; m_wait <= 0;
    end else begin
      bit uart, slv, mst, want, pe, fe, ov, have, ur;
      uart = (mode == 0); slv = (mode == 1); mst = (mode >= 2);
      want = par_odd ? !(^rx_data) : (^rx_data);
      pe   = uart && rx_done && par_en && (rx_par != want);
      fe   = uart && rx_done && (rx_stop[0] == 0);
      ov   = rx_done && rx_full && !(mst && !dbuf);
      have = tx_full || (fifo_en && fifo_cnt > 0);
      ur   = slv && dbuf && m_wait && sclk_edge && !have;
      if (!(slv && dbuf)) m_wait <= 0;
      else if (shift_done) m_wait <= 1;
      else if (sclk_edge) m_wait <= 0;
      m_fe <= fe ? 1'b1 : (rd ? 1'b0 : m_fe);
      m_pu <= (pe || ur) ? 1'b1 : (rd ? 1'b0 : m_pu);
      m_ov <= ov ? 1'b1 : (rd ? 1'b0 : m_ov);
    end
  end

  task automatic compare();
    logic [7:0] exp, msk;
    exp = 8'h00; exp[2] = m_fe; exp[3] = m_pu; exp[4] = m_ov;
    msk = 8'hFF;
    if (mode != 0) msk[2] = 1'b0;   // framing undefined in clocked modes
    if (mode >= 2) msk[3] = 1'b0;   // shared bit undefined in master
    n_chk++;
    if ((sts & msk) !== (exp & msk)) begin
      n_fail++;
      $display("FAIL %s model: actual %h expected %h", tag, sts & msk, exp & msk);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic expect_bit(int b, logic v, string req);
    n_chk++;
    if (sts[b] !== v) begin
      n_fail++;
      $display("FAIL %s bit%0d: actual %b expected %b", req, b, sts[b], v);
    end
  endtask

  task automatic rx_frame(logic [7:0] d, logic p, logic [1:0] st, logic full);
    rx_data = d; rx_par = p; rx_stop = st; rx_full = full; rx_done = 1'b1;
    tick();
    rx_done = 1'b0; rx_full = 1'b0; rx_stop = 2'b11;
  endtask

  task automatic do_read();
    rd = 1'b1; tick(); rd = 1'b0;
  endtask

  task automatic shift_then_edge(int gap);
    shift_done = 1'b1; tick(); shift_done = 1'b0;
    for (int i = 0; i < gap; i++) tick();
    sclk_edge = 1'b1; tick(); sclk_edge = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    tag = "R1"; expect_bit(2, 0, "R1"); expect_bit(3, 0, "R1"); expect_bit(4, 0, "R1");

    // R2 parity in UART mode
    tag = "R2"; mode = 0; par_en = 1; par_odd = 0;
    rx_frame(8'hA5, 1'b0, 2'b11, 0); expect_bit(3, 0, "R2");
    rx_frame(8'hA5, 1'b1, 2'b11, 0); expect_bit(3, 1, "R2");
    tag = "R8"; do_read(); expect_bit(3, 0, "R8");
    tag = "R2"; par_odd = 1;
    rx_frame(8'h01, 1'b0, 2'b11, 0); expect_bit(3, 0, "R2");
    rx_frame(8'h01, 1'b1, 2'b11, 0); expect_bit(3, 1, "R2");
    do_read();
    par_en = 0;
    rx_frame(8'h01, 1'b1, 2'b11, 0); expect_bit(3, 0, "R2");

    // R3 framing from first stop sample only
    tag = "R3";
    rx_frame(8'h3C, 1'b0, 2'b10, 0); expect_bit(2, 1, "R3");
    do_read(); expect_bit(2, 0, "R3");
    stop_len = 1;
    rx_frame(8'h3C, 1'b0, 2'b01, 0); expect_bit(2, 0, "R3");
    stop_len = 0;
    rx_frame(8'h3C, 1'b0, 2'b01, 0); expect_bit(2, 0, "R3");

    // R4 overrun
    tag = "R4";
    rx_frame(8'h11, 1'b0, 2'b11, 1); expect_bit(4, 1, "R4");
    do_read();
    mode = 2; dbuf = 0; tick();
    rx_frame(8'h11, 1'b0, 2'b11, 1); expect_bit(4, 0, "R4");
    dbuf = 1;
    rx_frame(8'h11, 1'b0, 2'b11, 1); expect_bit(4, 1, "R4");
    do_read();
    mode = 1; dbuf = 0;
    rx_frame(8'h11, 1'b0, 2'b11, 1); expect_bit(4, 1, "R4");
    do_read();

    // R5 underrun in slave mode
    tag = "R5"; mode = 1; dbuf = 1; tick();
    shift_then_edge(3); expect_bit(3, 1, "R5");
    do_read(); expect_bit(3, 0, "R5");
    tx_full = 1; shift_then_edge(2); expect_bit(3, 0, "R5");
    tx_full = 0;

    // R6 FIFO occupancy
    tag = "R6"; fifo_en = 1; fifo_cnt = 3'd2;
    shift_then_edge(1); expect_bit(3, 0, "R6");
    fifo_en = 0;
    shift_then_edge(1); expect_bit(3, 1, "R6");
    do_read();
    fifo_en = 1; fifo_cnt = 3'd0;
    shift_then_edge(0); expect_bit(3, 1, "R6");
    do_read(); fifo_en = 0;

    // R10 only first edge checked, late data in time
    tag = "R10";
    sclk_edge = 1; tick(); sclk_edge = 0; expect_bit(3, 0, "R10");
    shift_done = 1; tick(); shift_done = 0;
    tick(); tx_full = 1; sclk_edge = 1; tick(); sclk_edge = 0; tx_full = 0;
    expect_bit(3, 0, "R10");
    sclk_edge = 1; tick(); sclk_edge = 0; expect_bit(3, 0, "R10");

    // R7 no underrun without double buffer
    tag = "R7"; dbuf = 0; tick();
    shift_then_edge(2); expect_bit(3, 0, "R7");

    // R8 event in the clearing cycle wins
    tag = "R8"; mode = 0; tick();
    rx_frame(8'h00, 1'b0, 2'b11, 1); expect_bit(4, 1, "R8");
    rd = 1; rx_data = 8'h00; rx_stop = 2'b10; rx_done = 1; tick();
    rd = 0; rx_done = 0; rx_stop = 2'b11;
    expect_bit(2, 1, "R8"); expect_bit(4, 0, "R8");
    do_read();

    // R9 sticky across idle and mode change
    tag = "R9";
    rx_frame(8'h00, 1'b0, 2'b11, 1);
    repeat (5) tick();
    mode = 1; repeat (3) tick();
    mode = 2; dbuf = 0; repeat (3) tick();
    expect_bit(4, 1, "R9");
    do_read(); expect_bit(4, 0, "R9");

    tag = "R1";
    for (int i = 0; i < 4; i++) tick();
    expect_bit(0, 0, "R1"); expect_bit(7, 0, "R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule